// File: doc/BRIEF.md
# Multi-Channel Conversion Accumulator with Coherent Capture

This block sits behind an external analog-to-digital converter that delivers one result at a time, each carrying a valid strobe, a channel tag and a 12-bit value. For every one of four channels it keeps the most recent result and a wide running total of the results accepted while sampling is enabled. It also counts finished sample sequences and the clock cycles spent enabled.

Software never reads the live accumulators directly. A one-cycle capture request raises a self-clearing capture flag. On the following edge every live value is copied into a shadow bank. The shadow bank then stays fixed until the next capture, while accumulation goes on underneath it. As a result, a multi-word read of a 64-bit total, the sequence count and the cycle count always describes a single instant.

Top module: `adc_accum`

## Requirements
- R1: After reset every output is zero: latest results, all shadow values and the capture flag.
- R2: A result with `conv_valid` high is written into `latest` for the channel named by `conv_chan`, whether or not sampling is enabled. Channel k occupies bits [12k+11:12k]. It is visible after that clock edge.
- R3: While `sample_en` is high, each accepted result is added, zero-extended, into the 64-bit total of its own channel only. While `sample_en` is low, no total changes.
- R4: The 32-bit sequence count increments once for each accepted result tagged channel 3, the last channel, while `sample_en` is high.
- R5: The 64-bit cycle count increments on every clock edge at which `sample_en` is high, and holds while it is low.
- R6: On the first enabled cycle after `sample_en` was low, the totals, the sequence count and the cycle count restart from zero. That cycle's own contributions are included, so the cycle count reads 1 after it.
- R7: `snap_wr` high at an edge sets `snap_flag` for exactly one cycle. The flag then clears itself without any further write.
- R8: At the edge where `snap_flag` is high, the shadow bank takes the live values that held before that edge. A sample accepted at the same edge is excluded. Total k occupies `shd_sum` bits [64k+63:64k].
- R9: Between captures the shadow outputs keep their values, even while accumulation continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Sampling enable; a rising level restarts the accumulation |
| conv_valid | input | 1 | Converter result strobe |
| conv_chan | input | 2 | Channel tag of the result |
| conv_data | input | 12 | Conversion result |
| snap_wr | input | 1 | Capture request, one cycle |
| latest | output | 48 | Live latest result per channel |
| snap_flag | output | 1 | Self-clearing capture flag |
| shd_latest | output | 48 | Shadow latest results |
| shd_sum | output | 256 | Shadow per-channel totals |
| shd_seq | output | 32 | Shadow sequence count |
| shd_cyc | output | 64 | Shadow cycle count |

## Verification
The bench sweeps every 12-bit value through every channel. It gaps the strobe and periodically drops and re-raises the enable, and it compares every output to an arithmetic model on every cycle. It targets four corner cases:
- A capture that coincides with an accepted sample. A design that let the new sample into the shadow would show totals one sample too large.
- Re-enabling after a pause. A design that failed to restart would carry stale totals, and one that dropped the first cycle would report a cycle count one short.
- Long stretches with no capture. A leaking shadow would drift with the live values.
- A capture flag that fails to clear, which would show up as a flag held high for a second cycle.

// File: rtl/adc_acc_pkg.sv
package adc_acc_pkg;
   // width of an index able to address n items, never below one bit
   function automatic int idx_width(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/adc_acc_chan.sv
module adc_acc_chan #(
   parameter int SAMPLE_W = 12,
   parameter int SUM_W    = 64,
   parameter int CH_W     = 2,
   parameter int CH_ID    = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                restart,
   input  logic                conv_valid,
   input  logic [CH_W-1:0]     conv_chan,
   input  logic [SAMPLE_W-1:0] conv_data,
   output logic [SAMPLE_W-1:0] latest,
   output logic [SUM_W-1:0]    total
);
   localparam logic [CH_W-1:0] MY_TAG = CH_ID[CH_W-1:0];

   logic             hit;
   logic [SUM_W-1:0] base;
   logic [SUM_W-1:0] addend;

   assign hit    = conv_valid && (conv_chan == MY_TAG);
   assign base   = restart ? '0 : total;
   assign addend = hit ? SUM_W'(conv_data) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latest <= '0;
         total  <= '0;
      end else begin
         if (hit) latest <= conv_data;
         if (run) total <= base + addend;
      end
   end
endmodule

// File: rtl/adc_acc_counters.sv
module adc_acc_counters #(
   parameter int SEQ_W = 32,
   parameter int CYC_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic             seq_done,
   output logic [SEQ_W-1:0] seq_cnt,
   output logic [CYC_W-1:0] cyc_cnt
);
   logic [SEQ_W-1:0] seq_base;
   logic [CYC_W-1:0] cyc_base;

   assign seq_base = restart ? '0 : seq_cnt;
   assign cyc_base = restart ? '0 : cyc_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_cnt <= '0;
         cyc_cnt <= '0;
      end else if (run) begin
         seq_cnt <= seq_base + (seq_done ? SEQ_W'(1) : SEQ_W'(0));
         cyc_cnt <= cyc_base + CYC_W'(1);
      end
   end
endmodule

// File: rtl/adc_acc_shadow.sv
module adc_acc_shadow #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         capture,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (capture) q <= d;
   end
endmodule

// File: rtl/adc_accum.sv
module adc_accum
   import adc_acc_pkg::*;
#(
   parameter int NUM_CH        = 4,
   parameter int SAMPLE_W      = 12,
   parameter int SUM_W         = 64,
   parameter int SEQ_W         = 32,
   parameter int CYC_W         = 64,
   parameter bit SHADOW_LATEST = 1'b1,
   localparam int CH_W         = idx_width(NUM_CH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sample_en,
   input  logic                       conv_valid,
   input  logic [CH_W-1:0]            conv_chan,
   input  logic [SAMPLE_W-1:0]        conv_data,
   input  logic                       snap_wr,
   output logic [NUM_CH*SAMPLE_W-1:0] latest,
   output logic                       snap_flag,
   output logic [NUM_CH*SAMPLE_W-1:0] shd_latest,
   output logic [NUM_CH*SUM_W-1:0]    shd_sum,
   output logic [SEQ_W-1:0]           shd_seq,
   output logic [CYC_W-1:0]           shd_cyc
);
   localparam int LAT_BITS = NUM_CH * SAMPLE_W;
   localparam int SUM_BITS = NUM_CH * SUM_W;
   localparam int CNT_BITS = SEQ_W + CYC_W;
   localparam logic [CH_W-1:0] LAST_TAG = CH_W'(NUM_CH - 1);

   if (NUM_CH < 2) begin : g_err_ch
      $error("adc_accum: NUM_CH must be at least 2");
   end
   if (SUM_W < SAMPLE_W) begin : g_err_sum
      $error("adc_accum: SUM_W must not be narrower than SAMPLE_W");
   end
   if (SEQ_W < 1 || CYC_W < 1) begin : g_err_cnt
      $error("adc_accum: counter widths must be positive");
   end

   logic             en_q;
   logic             restart;
   logic             seq_done;
   logic [SUM_BITS-1:0] live_sum;
   logic [SEQ_W-1:0] live_seq;
   logic [CYC_W-1:0] live_cyc;

   assign restart  = sample_en && !en_q;
   assign seq_done = conv_valid && (conv_chan == LAST_TAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         snap_flag <= 1'b0;
      end else begin
         en_q      <= sample_en;
         snap_flag <= snap_wr;
      end
   end

   for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
      adc_acc_chan #(
         .SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W), .CH_W(CH_W), .CH_ID(k)
      ) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .run        (sample_en),
         .restart    (restart),
         .conv_valid (conv_valid),
         .conv_chan  (conv_chan),
         .conv_data  (conv_data),
         .latest     (latest[k*SAMPLE_W +: SAMPLE_W]),
         .total      (live_sum[k*SUM_W +: SUM_W])
      );
   end

   adc_acc_counters #(.SEQ_W(SEQ_W), .CYC_W(CYC_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (sample_en),
      .restart  (restart),
      .seq_done (seq_done),
      .seq_cnt  (live_seq),
      .cyc_cnt  (live_cyc)
   );

   adc_acc_shadow #(.W(SUM_BITS + CNT_BITS)) u_shd_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (snap_flag),
      .d       ({live_sum, live_seq, live_cyc}),
      .q       ({shd_sum, shd_seq, shd_cyc})
   );

   if (SHADOW_LATEST) begin : g_shd_lat
      adc_acc_shadow #(.W(LAT_BITS)) u_shd_lat (
         .clk     (clk),
         .rst_n   (rst_n),
         .capture (snap_flag),
         .d       (latest),
         .q       (shd_latest)
      );
   end else begin : g_pass_lat
      assign shd_latest = latest;
   end
endmodule

// File: rtl/adc_accum_chk.sv
module adc_accum_chk #(
   parameter int CH_W  = 2,
   parameter int SEQ_W = 32,
   parameter int CYC_W = 64,
   parameter int LAST  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sample_en,
   input logic             en_q,
   input logic             conv_valid,
   input logic [CH_W-1:0]  conv_chan,
   input logic             snap_wr,
   input logic             snap_flag,
   input logic [SEQ_W-1:0] live_seq,
   input logic [CYC_W-1:0] live_cyc,
   input logic [SEQ_W-1:0] shd_seq,
   input logic [CYC_W-1:0] shd_cyc
);
   assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      snap_wr |=> snap_flag);

   assert_flag_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_flag && !snap_wr) |=> !snap_flag);

   assert_cyc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && en_q) |=> live_cyc == $past(live_cyc) + CYC_W'(1));

   assert_cyc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_en |=> $stable(live_cyc) && $stable(live_seq));

   assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && en_q && conv_valid && conv_chan == CH_W'(LAST))
      |=> live_seq == $past(live_seq) + SEQ_W'(1));

   assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && !en_q) |=> live_cyc == CYC_W'(1));

   assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      snap_flag |=> shd_cyc == $past(live_cyc) && shd_seq == $past(live_seq));

   assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_flag |=> $stable(shd_cyc) && $stable(shd_seq));
endmodule

bind adc_accum adc_accum_chk #(
   .CH_W(CH_W), .SEQ_W(SEQ_W), .CYC_W(CYC_W), .LAST(NUM_CH - 1)
) u_adc_accum_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sample_en  (sample_en),
   .en_q       (en_q),
   .conv_valid (conv_valid),
   .conv_chan  (conv_chan),
   .snap_wr    (snap_wr),
   .snap_flag  (snap_flag),
   .live_seq   (live_seq),
   .live_cyc   (live_cyc),
   .shd_seq    (shd_seq),
   .shd_cyc    (shd_cyc)
);

// File: tb/test_adc_accum.sv
module test_adc_accum;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sample_en = 1'b0;
   logic         conv_valid = 1'b0;
   logic [1:0]   conv_chan = '0;
   logic [11:0]  conv_data = '0;
   logic         snap_wr = 1'b0;
   logic [47:0]  latest;
   logic         snap_flag;
   logic [47:0]  shd_latest;
   logic [255:0] shd_sum;
   logic [31:0]  shd_seq;
   logic [63:0]  shd_cyc;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // model state
   logic [11:0] m_lat [4];
   logic [63:0] m_sum [4];
   logic [31:0] m_seq;
   logic [63:0] m_cyc;
   logic        m_enq;
   logic        m_flag;
   logic [11:0] s_lat [4];
   logic [63:0] s_sum [4];
   logic [31:0] s_seq;
   logic [63:0] s_cyc;

   always #10 clk = ~clk;

   adc_accum i_adc_accum (
      .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .conv_valid(conv_valid),
      .conv_chan(conv_chan), .conv_data(conv_data), .snap_wr(snap_wr),
      .latest(latest), .snap_flag(snap_flag), .shd_latest(shd_latest),
      .shd_sum(shd_sum), .shd_seq(shd_seq), .shd_cyc(shd_cyc)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      for (int k = 0; k < 4; k++) begin
         chk(latest[k*12 +: 12] == m_lat[k], "R2", 64'(latest[k*12 +: 12]), 64'(m_lat[k]));
         chk(shd_latest[k*12 +: 12] == s_lat[k], "R8", 64'(shd_latest[k*12 +: 12]), 64'(s_lat[k]));
         chk(shd_sum[k*64 +: 64] == s_sum[k], "R3", shd_sum[k*64 +: 64], s_sum[k]);
      end
      chk(shd_seq == s_seq, "R4", 64'(shd_seq), 64'(s_seq));
      chk(shd_cyc == s_cyc, "R5", shd_cyc, s_cyc);
      chk(snap_flag == m_flag, "R7", 64'(snap_flag), 64'(m_flag));
   endtask

   // drive at negedge, model the edge, compare at the next negedge
   task automatic step(input logic v, input logic [1:0] ch, input logic [11:0] d,
                       input logic en, input logic sw);
      logic rs;
      conv_valid = v; conv_chan = ch; conv_data = d; sample_en = en; snap_wr = sw;
      @(posedge clk);
      if (m_flag) begin
         for (int k = 0; k < 4; k++) begin s_lat[k] = m_lat[k]; s_sum[k] = m_sum[k]; end
         s_seq = m_seq; s_cyc = m_cyc;
      end
      m_flag = sw;
      rs = en && !m_enq;
      m_enq = en;
      if (v) m_lat[ch] = d;
      if (en) begin
         if (rs) begin
            for (int k = 0; k < 4; k++) m_sum[k] = '0;
            m_seq = '0; m_cyc = '0;
         end
         if (v) m_sum[ch] = m_sum[ch] + 64'(d);
         if (v && ch == 2'd3) m_seq = m_seq + 32'd1;
         m_cyc = m_cyc + 64'd1;
      end
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      for (int k = 0; k < 4; k++) begin
         m_lat[k] = '0; m_sum[k] = '0; s_lat[k] = '0; s_sum[k] = '0;
      end
      m_seq = '0; m_cyc = '0; m_enq = 1'b0; m_flag = 1'b0; s_seq = '0; s_cyc = '0;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(latest == '0 && shd_latest == '0, "R1", 64'(latest), 64'd0);
      chk(shd_sum == '0 && shd_seq == '0 && shd_cyc == '0, "R1", shd_cyc, 64'd0);
      chk(snap_flag == 1'b0, "R1", 64'(snap_flag), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: latest tracks results even while disabled; R3: totals do not move
      step(1, 2'd1, 12'hABC, 0, 0);
      step(1, 2'd3, 12'h123, 0, 1);
      step(0, 2'd0, 12'h000, 0, 0);
      chk(shd_sum == '0, "R3", shd_sum[127:64], 64'd0);

      // R6: restart after enable; capture right after three enabled cycles
      step(1, 2'd0, 12'd5, 1, 0);
      step(1, 2'd3, 12'd7, 1, 0);
      step(0, 2'd0, 12'd0, 1, 1);
      step(0, 2'd0, 12'd0, 1, 0);
      chk(shd_cyc == 64'd3, "R6", shd_cyc, 64'd3);
      chk(shd_sum[63:0] == 64'd5, "R6", shd_sum[63:0], 64'd5);

      // R8: capture coincides with an accepted sample on channel 0
      step(0, 2'd0, 12'd0, 1, 1);
      step(1, 2'd0, 12'd100, 1, 0);
      chk(shd_sum[63:0] == 64'd5, "R8", shd_sum[63:0], 64'd5);

      // R9: shadow holds through many cycles of accumulation
      for (int i = 0; i < 50; i++) step(1, 2'(i), 12'(i * 3), 1, 0);
      chk(shd_cyc == 64'd5 && shd_sum[63:0] == 64'd5, "R9", shd_cyc, 64'd5);

      // restart semantics again: pause, then re-enable, R6
      step(0, 2'd0, 12'd0, 0, 0);
      step(1, 2'd2, 12'd9, 1, 1);
      step(0, 2'd0, 12'd0, 1, 0);
      chk(shd_cyc == 64'd1 && shd_sum[191:128] == 64'd9, "R6", shd_cyc, 64'd1);

      // sweep: every 12-bit value through every channel
      for (int i = 0; i < 16384; i++) begin
         step((i % 5) != 4, 2'(i % 4), 12'(i / 4), !((i % 1000) >= 500 && (i % 1000) < 520),
              (i % 13) == 0);
      end
      step(0, 2'd0, 12'd0, 1, 1);
      step(0, 2'd0, 12'd0, 1, 0);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule